// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of small signed integers on a grid of identical multiply-accumulate cells that all step on one clock. On a start pulse it captures both operand matrices, clears every accumulator and restarts its data counters. The left matrix A then enters the grid along the left edge, one row per edge cell, and moves one cell to the right per clock. The top matrix B enters along the top edge, one column per edge cell, and moves one cell down per clock. Two counter-driven sequencers delay each lane by its index and send zeros outside the real data, so the computation front crosses the grid diagonally. Cell (i,j) receives its first real operand pair i+j cycles after cell (0,0).

Each product term stays in the cell that computes it. After 3N-2 compute cycles every cell holds one element of C = A x B. The results then move down through the accumulators, one row per cycle, and leave at the bottom edge. A strobe marks each of the N output rows. The block is used by presenting both matrices, pulsing start, and collecting the rows while the strobe is high.

Top module: `mesh_matmul`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, done_o and out_valid_o are 0 and out_row_o is all zeros.
- R2: The matrices are captured in the clock edge that samples start_i high. Later changes on a_mat_i and b_mat_i do not change the results of that run. Element (r,c) of each matrix sits at bits [(r*N+c)*8 +: 8], as an 8-bit two's complement value.
- R3: Each output element equals the signed sum over k of A[i][k]*B[k][j], as a 20-bit two's complement value. Output element j of out_row_o sits at bits [j*20 +: 20].
- R4: done_o is 0 from the edge that samples start_i. It becomes 1 after exactly 3N-2 further clock edges and stays 1 until the next start.
- R5: out_valid_o is high for exactly N consecutive cycles. Its first high cycle is the cycle in which done_o first reads 1.
- R6: Rows leave bottom row first: the first valid cycle carries row N-1 of C, and each following valid cycle carries the row above.
- R7: A start pulse during computation or during readout abandons the current run, clears all accumulators and done_o, and begins a new run with the same timing as from idle.
- R8: Extreme operands (-128 x -128 and -128 x 127 in every term) give exact sums without wrap.
- R9: out_row_o is all zeros in every cycle in which out_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and begin a run |
| a_mat_i | input | N*N*8 | Left operand matrix A, row-major |
| b_mat_i | input | N*N*8 | Top operand matrix B, row-major |
| done_o | output | 1 | Accumulation finished for the current run |
| out_valid_o | output | 1 | out_row_o carries a result row |
| out_row_o | output | N*20 | Result row leaving the bottom edge |

## Verification
Clock edge e0 is the edge that samples start_i. done_o is first due after edge e0+3N-2, and from that edge the result rows are due one per cycle, N-1 first and row 0 last, up to edge e0+4N-3. The bench numbers every cycle from e0 onward. At each falling edge it compares done_o, out_valid_o and every element of out_row_o with the value a behavioural model gives for that cycle number. Readout starts in a fixed cycle, so any shift of even one cycle fails a check. Runs that are aborted by an early start are checked from their new e0.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COMP  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;
endpackage

// File: rtl/mesh_feeder.sv
// Edge sequencer: holds one operand matrix and skews it onto N lanes.
// TRANSPOSE=0: lane l streams row l (left edge). TRANSPOSE=1: lane l streams column l (top edge).
module mesh_feeder #(
  parameter int N         = 4,
  parameter int DW        = 8,
  parameter int CW        = 4,
  parameter bit TRANSPOSE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [N*N*DW-1:0] mat_i,
  output logic [N*DW-1:0]   lane_o
);
  logic [N*N*DW-1:0] mat_q;
  logic [CW-1:0]     dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mat_q  <= '0;
      dcnt_q <= '0;
    end else if (load_i) begin
      mat_q  <= mat_i;
      dcnt_q <= '0;
    end else if (run_i) begin
      dcnt_q <= dcnt_q + CW'(1);
    end
  end

  for (genvar l = 0; l < N; l++) begin : g_lane
    logic [CW:0] rel;
    logic        win;
    assign rel = {1'b0, dcnt_q} - (CW+1)'(l);
    assign win = (dcnt_q >= CW'(l)) && (rel < (CW+1)'(N));

    always_comb begin
      int unsigned p;
      lane_o[l*DW +: DW] = '0;
      for (int k = 0; k < N; k++) begin
        p = TRANSPOSE ? (k*N + l) : (l*N + k);
        if (win && rel == (CW+1)'(k)) lane_o[l*DW +: DW] = mat_q[p*DW +: DW];
      end
    end

    // zero padding ahead of the skewed data
    assert_pad_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !load_i && dcnt_q < CW'(l)) |-> (lane_o[l*DW +: DW] == '0));
  end
endmodule

// File: rtl/mesh_pe.sv
module mesh_pe #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 mac_en_i,
  input  logic                 shift_en_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [AW-1:0] acc_i,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] b_o,
  output logic signed [AW-1:0] acc_o
);
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prod_ext;
  logic signed [AW-1:0]   acc_q;
  logic signed [DW-1:0]   a_q, b_q;

  assign prod     = a_i * b_i;
  assign prod_ext = {{(AW-2*DW){prod[2*DW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (mac_en_i) begin
      acc_q <= acc_q + prod_ext;
      a_q   <= a_i;
      b_q   <= b_i;
    end else if (shift_en_i) begin
      acc_q <= acc_i;  // readout: take the value from the cell above
    end
  end

  assign a_o   = a_q;
  assign b_o   = b_q;
  assign acc_o = acc_q;

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0 && a_o == '0 && b_o == '0));

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !mac_en_i && !shift_en_i) |=> $stable(acc_o));

  assert_phase_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mac_en_i && shift_en_i));
endmodule

// File: rtl/mesh_ctrl.sv
module mesh_ctrl
  import mesh_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic mac_en_o,
  output logic shift_en_o,
  output logic done_o
);
  localparam logic [CW-1:0] LAST_MAC   = CW'(3*N-3);
  localparam logic [CW-1:0] LAST_SHIFT = CW'(N-1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      ph_q   <= PH_COMP;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_COMP: begin
          if (cnt_q == LAST_MAC) begin
            ph_q   <= PH_SHIFT;
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_SHIFT: begin
          if (cnt_q == LAST_SHIFT) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign mac_en_o   = (ph_q == PH_COMP);
  assign shift_en_o = (ph_q == PH_SHIFT);
  assign done_o     = done_q;

  assert_start_restarts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && mac_en_o));

  assert_done_after_mac_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(mac_en_o) && $past(cnt_q) == LAST_MAC));

  assert_shift_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(shift_en_o) && !$past(start_i)) |-> ($past(cnt_q) == LAST_SHIFT));
endmodule

// File: rtl/mesh_matmul.sv
module mesh_matmul #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N*N*DW-1:0] a_mat_i,
  input  logic [N*N*DW-1:0] b_mat_i,
  output logic              done_o,
  output logic              out_valid_o,
  output logic [N*AW-1:0]   out_row_o
);
  localparam int CW = $clog2(3*N);

  logic            mac_en, shift_en;
  logic [N*DW-1:0] left_lanes, top_lanes;

  logic signed [DW-1:0] a_w   [N][N];
  logic signed [DW-1:0] b_w   [N][N];
  logic signed [AW-1:0] acc_w [N][N];

  mesh_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mac_en_o   (mac_en),
    .shift_en_o (shift_en),
    .done_o     (done_o)
  );

  mesh_feeder #(.N(N), .DW(DW), .CW(CW), .TRANSPOSE(1'b0)) u_feed_left (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .run_i  (mac_en),
    .mat_i  (a_mat_i),
    .lane_o (left_lanes)
  );

  mesh_feeder #(.N(N), .DW(DW), .CW(CW), .TRANSPOSE(1'b1)) u_feed_top (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .run_i  (mac_en),
    .mat_i  (b_mat_i),
    .lane_o (top_lanes)
  );

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic signed [DW-1:0] a_in, b_in;
      logic signed [AW-1:0] acc_in;

      if (j == 0) begin : g_left_edge
        assign a_in = left_lanes[i*DW +: DW];
      end else begin : g_left_inner
        assign a_in = a_w[i][j-1];
      end

      if (i == 0) begin : g_top_edge
        assign b_in   = top_lanes[j*DW +: DW];
        assign acc_in = '0;
      end else begin : g_top_inner
        assign b_in   = b_w[i-1][j];
        assign acc_in = acc_w[i-1][j];
      end

      mesh_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (start_i),
        .mac_en_i   (mac_en),
        .shift_en_i (shift_en),
        .a_i        (a_in),
        .b_i        (b_in),
        .acc_i      (acc_in),
        .a_o        (a_w[i][j]),
        .b_o        (b_w[i][j]),
        .acc_o      (acc_w[i][j])
      );
    end
  end

  assign out_valid_o = shift_en;

  for (genvar j = 0; j < N; j++) begin : g_out
    assign out_row_o[j*AW +: AW] = shift_en ? acc_w[N-1][j] : '0;
  end

  assert_valid_needs_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> done_o);

  assert_valid_starts_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $rose(done_o));
endmodule

// File: tb/mesh_matmul_test.sv
module mesh_matmul_test;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 20;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [N*N*DW-1:0] a_mat_i = '0;
  logic [N*N*DW-1:0] b_mat_i = '0;
  logic              done_o, out_valid_o;
  logic [N*AW-1:0]   out_row_o;

  int  n_chk = 0, n_fail = 0;
  int  am [N][N];
  int  bm [N][N];
  int  cm [N][N];
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  mesh_matmul #(.N(N), .DW(DW), .AW(AW)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .a_mat_i     (a_mat_i),
    .b_mat_i     (b_mat_i),
    .done_o      (done_o),
    .out_valid_o (out_valid_o),
    .out_row_o   (out_row_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // mode 0 random, 1 all -128, 2 -128 x 127, 3 identity x random
  task automatic gen_case(input int mode);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        unique case (mode)
          1: begin am[r][c] = -128; bm[r][c] = -128; end
          2: begin am[r][c] = -128; bm[r][c] = 127; end
          3: begin am[r][c] = (r == c) ? 1 : 0; bm[r][c] = int'($urandom_range(0, 255)) - 128; end
          default: begin
            am[r][c] = int'($urandom_range(0, 255)) - 128;
            bm[r][c] = int'($urandom_range(0, 255)) - 128;
          end
        endcase
      end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        cm[r][c] = 0;
        for (int k = 0; k < N; k++) cm[r][c] += am[r][k] * bm[k][c];
      end
  endtask

  task automatic check_reset_state(input string when);
    chk(done_o == 1'b0, "R1", {"done_o ", when}, done_o, 0);
    chk(out_valid_o == 1'b0, "R1", {"out_valid_o ", when}, out_valid_o, 0);
    chk(out_row_o == '0, "R1", {"out_row_o ", when}, out_row_o, 0);
  endtask

  // k = number of clock edges since the edge that sampled start_i
  task automatic check_cycle(input int k);
    bit exp_done, exp_valid;
    int r;
    logic signed [AW-1:0] v;
    exp_done  = (k >= 3*N-2);
    exp_valid = (k >= 3*N-2) && (k <= 4*N-3);
    chk(done_o == exp_done, "R4", $sformatf("done_o k=%0d", k), done_o, exp_done);
    chk(out_valid_o == exp_valid, "R5", $sformatf("out_valid_o k=%0d", k), out_valid_o, exp_valid);
    r = N-1-(k-(3*N-2));
    for (int j = 0; j < N; j++) begin
      v = out_row_o[j*AW +: AW];
      if (exp_valid)
        chk(int'(v) == cm[r][j], "R3/R6", $sformatf("row %0d col %0d k=%0d", r, j, k), v, cm[r][j]);
      else
        chk(v == '0, "R9", $sformatf("idle col %0d k=%0d", j, k), v, 0);
    end
  endtask

  task automatic run_case(input int stop_k, input bit scramble);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        a_mat_i[(r*N+c)*DW +: DW] = DW'(am[r][c]);
        b_mat_i[(r*N+c)*DW +: DW] = DW'(bm[r][c]);
      end
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (scramble) begin  // R2: inputs change after capture
      a_mat_i = ~a_mat_i;
      b_mat_i = {b_mat_i[DW-1:0], b_mat_i[N*N*DW-1:DW]};
    end
    check_cycle(0);
    for (int k = 1; k <= stop_k; k++) begin
      @(negedge clk);
      check_cycle(k);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1
    repeat (3) @(negedge clk);
    check_reset_state("in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state("after release");

    gen_case(0); run_case(4*N+1, 1'b0);  // R3 R4 R5 R6 R9
    gen_case(0); run_case(4*N+1, 1'b1);  // R2
    gen_case(1); run_case(4*N,   1'b0);  // R8
    gen_case(2); run_case(4*N,   1'b1);  // R8 R2
    gen_case(3); run_case(4*N,   1'b0);  // R3
    gen_case(0); run_case(5,     1'b0);  // R7 abort in compute
    gen_case(0); run_case(4*N,   1'b0);
    gen_case(0); run_case(3*N-1, 1'b0);  // R7 abort in readout
    gen_case(0); run_case(4*N+2, 1'b0);
    gen_case(0); run_case(4*N,   1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule